// File: doc/BRIEF.md
# Four-Bit-Selected 32-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a simple single-cycle integer datapath. It takes two 32-bit operands and a 4-bit operation selector, and it returns a 32-bit result. A one-bit flag goes high whenever that result is all zeros. Branch logic uses this flag: subtracting two registers and testing the flag tells whether they are equal.

The operation encoding is sparse, and the selector values are fixed because the control logic upstream produces them. The operations are bitwise AND, OR and NOR, wrapping addition and subtraction, and a signed set-less-than. Any selector value outside that set gives a zero result. Nothing is registered, so the outputs follow the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: Selector 4'b0000 gives the bitwise AND of the two operands.
- R2: Selector 4'b0001 gives the bitwise OR of the two operands.
- R3: Selector 4'b0010 gives op_a + op_b modulo 2^32. A carry out of bit 31 is dropped and is not indicated anywhere.
- R4: Selector 4'b0110 gives op_a - op_b modulo 2^32. A borrow is dropped and is not indicated anywhere.
- R5: Selector 4'b0111 treats both operands as signed two's-complement values. The result is 1 in bit 0 when op_a < op_b and 0 otherwise, and bits 31..1 are always zero. The comparison stays correct even when the difference overflows.
- R6: Selector 4'b1100 gives the bitwise NOR of the two operands.
- R7: is_zero is 1 exactly when all 32 result bits are 0, for every selector value.
- R8: Every selector value other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtraction) |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation selector |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
The bench targets the set-less-than cases where the plain sign of the difference gives the wrong answer. Examples are the most negative value against a positive one and the most positive value against minus one. A design that skipped the overflow correction would report the opposite order there. It also drives sums that wrap to exactly zero and subtractions of equal operands, which should raise the zero flag. A design that kept a carry or borrow, or tied the flag to the adder alone, would fail those cases. Every unlisted selector is driven with all-ones operands, so a decoder that falls through to some other operation shows up as a nonzero result.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32,
  parameter int SELW  = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [SELW-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);
  localparam logic [SELW-1:0] SEL_AND = SELW'(4'b0000);
  localparam logic [SELW-1:0] SEL_OR  = SELW'(4'b0001);
  localparam logic [SELW-1:0] SEL_ADD = SELW'(4'b0010);
  localparam logic [SELW-1:0] SEL_SUB = SELW'(4'b0110);
  localparam logic [SELW-1:0] SEL_SLT = SELW'(4'b0111);
  localparam logic [SELW-1:0] SEL_NOR = SELW'(4'b1100);
  localparam int MSB = WIDTH - 1;

  logic             negate;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic             less;
  logic [WIDTH-1:0] orv;

  assign negate = (op_sel == SEL_SUB) || (op_sel == SEL_SLT);
  assign b_eff  = negate ? ~op_b : op_b;
  assign sum    = op_a + b_eff + {{(WIDTH-1){1'b0}}, negate};
  assign ovf    = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
  assign less   = sum[MSB] ^ ovf;
  assign orv    = op_a | op_b;

  always_comb begin
    unique case (op_sel)
      SEL_AND:          result = op_a & op_b;
      SEL_OR:           result = orv;
      SEL_ADD, SEL_SUB: result = sum;
      SEL_SLT:          result = {{(WIDTH-1){1'b0}}, less};
      SEL_NOR:          result = ~orv;
      default:          result = '0;
    endcase
  end

  assign is_zero = ~|result;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32,
  parameter int SELW  = 4
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [SELW-1:0]  op_sel,
  input logic [WIDTH-1:0] result,
  input logic             is_zero
);
  logic known;
  assign known = op_sel inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  always_comb begin
    if (op_sel == 4'b0000) a_r1_and: assert final (result == (op_a & op_b));
    if (op_sel == 4'b0001) a_r2_or: assert final (result == (op_a | op_b));
    if (op_sel == 4'b0010) a_r3_add_wrap: assert final (result == WIDTH'(op_a + op_b));
    if (op_sel == 4'b0110) a_r4_sub_wrap: assert final (result == WIDTH'(op_a - op_b));
    if (op_sel == 4'b0111) a_r5_slt_upper_clear: assert final (result[WIDTH-1:1] == '0);
    if (op_sel == 4'b1100) a_r6_nor_disjoint: assert final ((result & (op_a | op_b)) == '0);
    a_r7_zero_flag: assert final (is_zero == (result == '0));
    if (!known) a_r8_unlisted_zero: assert final (result == '0 && is_zero);
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .SELW(SELW)) u_chk (
  .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result), .is_zero(is_zero)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  sel = '0;
  logic [31:0] res;
  logic        zf;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_core u_dut (.op_a(a), .op_b(b), .op_sel(sel), .result(res), .is_zero(zf));

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] s);
    longint sx, sy;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (s)
      4'd0:  return x & y;
      4'd1:  return x | y;
      4'd2:  return 32'((longint'(x) + longint'(y)) % 64'h1_0000_0000);
      4'd6:  return 32'((longint'(x) - longint'(y) + 64'h1_0000_0000) % 64'h1_0000_0000);
      4'd7:  return (sx < sy) ? 32'd1 : 32'd0;
      4'd12: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd6: return "R4";  4'd7: return "R5";  4'd12: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [3:0] s);
    logic [31:0] exp;
    @(posedge clk);
    a = x; b = y; sel = s;
    @(negedge clk);
    exp = model(x, y, s);
    total++;
    if (res !== exp) begin
      bad++;
      $display("FAIL %s sel=%b a=%h b=%h result actual=%h expected=%h", tag_of(s), s, x, y, res, exp);
    end
    total++;
    if (zf !== (exp == 32'd0)) begin
      bad++;
      $display("FAIL R7 sel=%b is_zero actual=%b expected=%b", s, zf, exp == 32'd0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (res !== 32'd0 || zf !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset idle actual=%h/%b expected=00000000/1", res, zf);
    end
    run(32'hF0F0_1234, 32'h0FF0_FF00, 4'd0);   // R1
    run(32'hAAAA_0000, 32'h5555_0000, 4'd0);   // R1 and R7 disjoint
    run(32'hAAAA_0000, 32'h0000_5555, 4'd1);   // R2
    run(32'h0, 32'h0, 4'd1);                   // R2 zero
    run(32'hFFFF_FFFF, 32'h1, 4'd2);           // R3 wrap to zero
    run(32'h7FFF_FFFF, 32'h1, 4'd2);           // R3 signed overflow, no flag
    run(32'h0, 32'h1, 4'd6);                   // R4 borrow wrap
    run(32'h1234_5678, 32'h1234_5678, 4'd6);   // R4 equal gives zero flag
    run(32'h8000_0000, 32'h1, 4'd7);           // R5 diff overflows, expect 1
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd7);   // R5 diff overflows, expect 0
    run(32'hFFFF_FFFF, 32'h0, 4'd7);           // R5 -1 < 0
    run(32'h5, 32'h5, 4'd7);                   // R5 equal
    run(32'h0, 32'h0, 4'd12);                  // R6 all ones
    run(32'hFFFF_0000, 32'h0000_FFFF, 4'd12);  // R6 to zero
    for (int s = 0; s < 16; s++) run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(s)); // R8 among all
    for (int i = 0; i < 3000; i++) begin
      x = $urandom; y = $urandom;
      if (i % 7 == 0) y = x;
      if (i % 11 == 0) x = {~y[31], $urandom_range(0, 1) ? y[30:0] : 31'h0};
      run(x, y, 4'($urandom_range(0, 15)));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule